// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Merger

This block keeps the floating-point status word of an execution pipeline honest after each completed operation. The execution unit leaves a status word behind, and that word may carry invalid or underflow flags raised for reasons the IEEE rules do not recognise. On every update strobe the block clears those two flags unless the previous committed status already had them set. It then sets the flags for the exceptions that the current operation really raised, and it commits the result. The committed result becomes both the new status output and the snapshot that the next update compares against.

Every other sticky flag, and every non-flag bit of the status word, passes through unchanged. The block also raises a one-cycle trap request when software trapping is enabled globally and at least one exception of the current operation has its own enable set. Flags already present in the incoming status word never cause a trap. The bit positions of the five flags are parameters. The defaults are inexact 3, underflow 4, divide-by-zero 5, overflow 6 and invalid 7, in a 16-bit status word.

Top module: `fp_sticky_merge`

## Requirements
- R1: After reset, `statusOut`, `snapOut` and `trapReq` are all zero.
- R2: On an update, the invalid bit (default bit 7) and the underflow bit (default bit 4) of `statusIn` reach `statusOut` only if the same bit is set in the snapshot, unless the current operation raises that exception.
- R3: On an update, every other bit of `statusIn` reaches `statusOut` unchanged. This covers the inexact, divide-by-zero and overflow flags and all non-flag bits.
- R4: Bits of `curExc` outside the five flag positions have no effect on `statusOut`.
- R5: A `curExc` bit at a flag position sets that bit of `statusOut`. The OR is applied after the clearing of R2, so a freshly raised invalid or underflow flag is kept even when the snapshot has that bit clear.
- R6: After every update, `snapOut` equals the new `statusOut`. The next update uses this snapshot.
- R7: `trapReq` is raised only when `swTrapEn` is set and some flag of `curExc` has its enable bit set in `trapMask`. The enable bits are ordered [0] inexact, [1] invalid, [2] divide-by-zero, [3] underflow, [4] overflow.
- R8: `trapReq` is a single-cycle pulse in the same cycle that `statusOut` takes the new value. Without `updStrobe`, `statusOut` and `snapOut` hold and `trapReq` is low.
- R9: Flags that are present in `statusIn` but not in `curExc` never cause a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updStrobe | input | 1 | Commit the current operation's status |
| statusIn | input | STATUS_W | Status word as left by the execution unit |
| curExc | input | STATUS_W | Exceptions raised by the current operation, in status-bit positions |
| trapMask | input | 5 | Per-exception trap enables (order in R7) |
| swTrapEn | input | 1 | Global software trap enable |
| statusOut | output | STATUS_W | Committed status word |
| snapOut | output | STATUS_W | Snapshot of the last committed status |
| trapReq | output | 1 | Trap request pulse |

## Verification
The block samples `updStrobe` at a rising edge, and all three results become visible directly after that edge. Those results are the new status, the new snapshot and the trap pulse. The bench therefore drives inputs on a falling edge and checks results on the next falling edge. The pulse must already be gone one further falling edge later if no strobe follows. Because the snapshot carries history, the table walk feeds a bench-side reference model that tracks its own snapshot.

// File: rtl/fpsm_pkg.sv
package fpsm_pkg;

  localparam int NUM_FLAGS = 5;

  // Index of each flag inside the trap enable vector.
  localparam int IDX_INX = 0;
  localparam int IDX_INV = 1;
  localparam int IDX_DVZ = 2;
  localparam int IDX_UND = 3;
  localparam int IDX_OVF = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;
    logic trapFire;
  } fpsmStrobe_t;

endpackage

// File: rtl/fpsm_ctrl.sv
module fpsm_ctrl
  import fpsm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        updStrobe,
  input  logic        swTrapEn,
  input  logic        excHit,
  output fpsmStrobe_t strobe,
  output logic        trapReq
);

  always_comb begin
    strobe.commit   = updStrobe;
    strobe.trapFire = updStrobe & swTrapEn & excHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= strobe.trapFire;
  end

  AST_TRAP_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(updStrobe)); // R8
  AST_TRAP_GLOBAL_EN: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(swTrapEn)); // R7
  AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |=> !trapReq); // R8

endmodule

// File: rtl/fpsm_datapath.sv
module fpsm_datapath
  import fpsm_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int POS_INX  = 3,
  parameter int POS_INV  = 7,
  parameter int POS_DVZ  = 5,
  parameter int POS_UND  = 4,
  parameter int POS_OVF  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpsmStrobe_t          strobe,
  input  logic [STATUS_W-1:0]  statusIn,
  input  logic [STATUS_W-1:0]  curExc,
  input  logic [NUM_FLAGS-1:0] trapMask,
  output logic                 excHit,
  output logic [STATUS_W-1:0]  statusOut,
  output logic [STATUS_W-1:0]  snapOut
);

  localparam int FLAG_POS [NUM_FLAGS] = '{POS_INX, POS_INV, POS_DVZ, POS_UND, POS_OVF};

  logic [STATUS_W-1:0]  flagMask;
  logic [STATUS_W-1:0]  clrMask;
  logic [NUM_FLAGS-1:0] curFlags;
  logic [STATUS_W-1:0]  merged;
  logic [STATUS_W-1:0]  statusReg;
  logic [STATUS_W-1:0]  snapReg;

  // Gather the current operation's exceptions into trap-enable order.
  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    assign curFlags[k] = curExc[FLAG_POS[k]];
  end

  always_comb begin
    flagMask = '0;
    for (int k = 0; k < NUM_FLAGS; k++) flagMask[FLAG_POS[k]] = 1'b1;
    clrMask = '0;
    clrMask[POS_INV] = 1'b1;
    clrMask[POS_UND] = 1'b1;
  end

  // Drop spurious invalid/underflow, then merge in real exceptions.
  assign merged = (statusIn & (~clrMask | snapReg)) | (curExc & flagMask);
  assign excHit = |(curFlags & trapMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      snapReg   <= '0;
    end else if (strobe.commit) begin
      statusReg <= merged;
      snapReg   <= merged;
    end
  end

  assign statusOut = statusReg;
  assign snapOut   = snapReg;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(statusOut) && $stable(snapOut)); // R8
  AST_SNAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> snapOut == statusOut); // R6
  AST_PASS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ((statusOut ^ $past(statusIn)) & ~clrMask & ~flagMask) == '0); // R3
  AST_EXC_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (statusOut & $past(curExc & flagMask)) == $past(curExc & flagMask)); // R5
  AST_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (statusOut & clrMask & ~$past(snapReg) & ~$past(curExc)) == '0); // R2

endmodule

// File: rtl/fp_sticky_merge.sv
module fp_sticky_merge
  import fpsm_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int POS_INX  = 3,
  parameter int POS_INV  = 7,
  parameter int POS_DVZ  = 5,
  parameter int POS_UND  = 4,
  parameter int POS_OVF  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updStrobe,
  input  logic [STATUS_W-1:0]  statusIn,
  input  logic [STATUS_W-1:0]  curExc,
  input  logic [NUM_FLAGS-1:0] trapMask,
  input  logic                 swTrapEn,
  output logic [STATUS_W-1:0]  statusOut,
  output logic [STATUS_W-1:0]  snapOut,
  output logic                 trapReq
);

  fpsmStrobe_t strobe;
  logic        excHit;

  fpsm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .updStrobe (updStrobe),
    .swTrapEn  (swTrapEn),
    .excHit    (excHit),
    .strobe    (strobe),
    .trapReq   (trapReq)
  );

  fpsm_datapath #(
    .STATUS_W (STATUS_W),
    .POS_INX  (POS_INX),
    .POS_INV  (POS_INV),
    .POS_DVZ  (POS_DVZ),
    .POS_UND  (POS_UND),
    .POS_OVF  (POS_OVF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .statusIn  (statusIn),
    .curExc    (curExc),
    .trapMask  (trapMask),
    .excHit    (excHit),
    .statusOut (statusOut),
    .snapOut   (snapOut)
  );

endmodule

// File: tb/fp_sticky_merge_tb.sv
module fp_sticky_merge_tb;

  localparam int W = 16;
  localparam int P_INX = 3, P_UND = 4, P_DVZ = 5, P_OVF = 6, P_INV = 7;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         updStrobe = 1'b0;
  logic [W-1:0] statusIn = '0;
  logic [W-1:0] curExc = '0;
  logic [4:0]   trapMask = '0;
  logic         swTrapEn = 1'b0;
  logic [W-1:0] statusOut, snapOut;
  logic         trapReq;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] modelSnap = '0;

  always #5 clk = ~clk;

  fp_sticky_merge u_dut (
    .clk(clk), .rstN(rstN), .updStrobe(updStrobe), .statusIn(statusIn),
    .curExc(curExc), .trapMask(trapMask), .swTrapEn(swTrapEn),
    .statusOut(statusOut), .snapOut(snapOut), .trapReq(trapReq)
  );

  // Fields: statusIn[37:22], curExc[21:6], trapMask[5:1], swTrapEn[0]
  localparam logic [37:0] VECS [0:7] = '{
    {16'hFFFF, 16'h0000, 5'b11111, 1'b1},
    {16'h0000, 16'h0090, 5'b00000, 1'b1},
    {16'h0090, 16'h0000, 5'b11111, 1'b1},
    {16'h1234, 16'h0008, 5'b00001, 1'b1},
    {16'hA5A5, 16'h0040, 5'b10000, 1'b0},
    {16'h00F8, 16'h0020, 5'b00100, 1'b1},
    {16'h0000, 16'hFF07, 5'b11111, 1'b1},
    {16'h5A5A, 16'h0010, 5'b01000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refStatus(input logic [W-1:0] sIn,
      input logic [W-1:0] snap, input logic [W-1:0] exc);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (i == P_INV || i == P_UND) r[i] = sIn[i] && snap[i];
      else                          r[i] = sIn[i];
      if (i == P_INX || i == P_INV || i == P_DVZ || i == P_UND || i == P_OVF)
        r[i] = r[i] || exc[i];
    end
    return r;
  endfunction

  function automatic logic refTrap(input logic [W-1:0] exc, input logic [4:0] m, input logic en);
    logic hit;
    hit = (exc[P_INX] & m[0]) | (exc[P_INV] & m[1]) | (exc[P_DVZ] & m[2]) |
          (exc[P_UND] & m[3]) | (exc[P_OVF] & m[4]);
    return hit & en;
  endfunction

  // Drive on a falling edge; results are checked on the next falling edge.
  task automatic doUpdate(input logic [W-1:0] s, input logic [W-1:0] e,
                          input logic [4:0] m, input logic en);
    @(negedge clk);
    statusIn = s; curExc = e; trapMask = m; swTrapEn = en; updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    statusIn = 16'hFFFF; curExc = 16'hFFFF; trapMask = 5'b11111; swTrapEn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] expS;
    logic [W-1:0] prevS;
    logic         expT;
    repeat (3) @(negedge clk);
    check("R1 status reset", statusOut, 0);
    check("R1 snapshot reset", snapOut, 0);
    check("R1 trap reset", trapReq, 0);
    rstN = 1'b1;

    // Table walk against reference model
    modelSnap = '0;
    for (int v = 0; v < 8; v++) begin
      expS = refStatus(VECS[v][37:22], modelSnap, VECS[v][21:6]);
      expT = refTrap(VECS[v][21:6], VECS[v][5:1], VECS[v][0]);
      doUpdate(VECS[v][37:22], VECS[v][21:6], VECS[v][5:1], VECS[v][0]);
      check("R2/R3/R5 table status", statusOut, expS);
      check("R6 table snapshot", snapOut, expS);
      check("R7 table trap", trapReq, expT);
      modelSnap = expS;
    end

    // Directed: spurious invalid/underflow cleared with clean snapshot
    rstN = 1'b0; @(negedge clk); @(negedge clk); rstN = 1'b1;
    doUpdate(16'hFFFF, 16'h0000, 5'b00000, 1'b0);
    check("R2 spurious cleared", statusOut, 16'hFF6F);
    check("R3 passthrough bits", statusOut & 16'hFF6F, 16'hFF6F);
    // Fresh invalid raised survives clean snapshot
    doUpdate(16'h0000, 16'h0080, 5'b00000, 1'b0);
    check("R5 raised invalid kept", statusOut, 16'h0080);
    check("R6 snapshot copy", snapOut, 16'h0080);
    // Invalid survives because snapshot has it; underflow does not
    doUpdate(16'h0090, 16'h0000, 5'b00000, 1'b0);
    check("R2 invalid kept by snapshot", statusOut, 16'h0080);
    // Non-flag exception bits ignored
    doUpdate(16'h0000, 16'hFF07, 5'b11111, 1'b1);
    check("R4 non-flag exc ignored", statusOut, 16'h0000);
    check("R4 non-flag exc no trap", trapReq, 0);
    // Trap gating
    doUpdate(16'h0000, 16'h0020, 5'b00100, 1'b1);
    check("R7 trap divide-by-zero enabled", trapReq, 1);
    check("R5 divide-by-zero set", statusOut, 16'h0020);
    prevS = statusOut;
    idleCycle();
    check("R8 trap single pulse", trapReq, 0);
    check("R8 status held when idle", statusOut, prevS);
    check("R8 snapshot held when idle", snapOut, prevS);
    doUpdate(16'h0000, 16'h0020, 5'b00100, 1'b0);
    check("R7 trap blocked by global enable", trapReq, 0);
    doUpdate(16'h0000, 16'h0020, 5'b11011, 1'b1);
    check("R7 trap blocked by per-flag enable", trapReq, 0);
    doUpdate(16'h0010, 16'h0010, 5'b01000, 1'b1);
    check("R7 trap underflow enabled", trapReq, 1);
    // Incoming flags never trap
    doUpdate(16'h00F8, 16'h0000, 5'b11111, 1'b1);
    check("R9 incoming flags no trap", trapReq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule